// File: doc/BRIEF.md
# Instruction Boundary Picker

This block sits between an instruction cache and the instruction decoders. The cache hands it aligned 16-byte fetch groups. With each byte come a begin marker, a finish marker and a 2-bit class field. The picker appends each group to a 32-byte byte buffer and cuts whole variable-length instructions of 1 to 15 bytes out of that buffer. It finds their boundaries only from the stored markers and never parses opcodes. An instruction may straddle two fetch groups; it is emitted once both halves are buffered.

Each emitted instruction carries its bytes, its length, the offset of its first byte inside its fetch group and a decode-path code. The code says whether the instruction becomes one macro-op, two macro-ops, or goes to the microcoded path. Up to three instructions leave per cycle, oldest in lane 0. Both streams use valid/ready. A fetch group is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` drops whenever more than 16 bytes are buffered. The output lanes form one bundle. `out_valid` shows how many lanes hold instructions. A high `out_ready` takes every valid lane on that edge. A low `out_ready` holds the lanes and their contents unchanged. A flush input empties the buffer in a single cycle. An instruction whose finish marker is missing raises a one-cycle error pulse and is dropped.

Top module: `insn_boundary_picker`

## Requirements
- R1: A fetch group is written into the buffer only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `flush` is low and the buffer holds at most 16 bytes. After an accepted group the buffer holds at least 16 bytes.
- R2: An instruction begins at a byte whose begin marker is set. It ends at the first byte at or after that one whose finish marker is set. Its length (1 to 15) appears on `out_len`. Its bytes appear in order on `out_bytes`, with byte 0 in the lowest 8 bits of the lane. Lane bytes past the length are zero.
- R3: An instruction whose bytes arrive in two consecutive fetch groups is emitted whole, with the same content as one that lies inside a single group.
- R4: `out_path` is taken from the class field of the instruction's first byte. Class 00 gives 00 (single macro-op), 01 gives 01 (double), and 10 or 11 give 10 (microcoded vector path). The class fields of the other bytes are ignored.
- R5: Up to three instructions are offered per cycle. Valid lanes fill from lane 0 upward with no gaps, in program order, with lane 0 the oldest.
- R6: While lane 0 is valid and `out_ready` is low, no instruction is consumed. The content of lane 0 stays unchanged until it is taken or flushed.
- R7: `out_ofs` gives the position (0 to 15) of the instruction's first byte inside its 16-byte fetch group. Positions count from the first group after reset or flush.
- R8: Bytes at the head of the buffer that carry no begin marker and belong to no instruction are discarded without any output and without an error.
- R9: If no finish marker lies within 15 bytes of a begin marker, `err_drop` pulses high for one cycle. The 15 bytes from that begin byte are discarded, and no instruction is emitted for them. The instructions that follow are still emitted.
- R10: While `flush` is high, `in_ready` and `out_valid` are low. On the next cycle the buffer is empty, so `out_valid` stays low until new groups arrive.
- R11: After reset the buffer is empty: `out_valid` is zero, `in_ready` is high and `err_drop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all buffered bytes and pending instructions |
| in_valid | input | 1 | Fetch group offered |
| in_ready | output | 1 | Buffer can take a fetch group |
| in_bytes | input | 128 | Fetch group bytes, byte 0 in bits 7:0 |
| in_start | input | 16 | Begin marker per byte |
| in_end | input | 16 | Finish marker per byte |
| in_class | input | 32 | 2-bit path class per byte, byte n in bits 2n+1:2n |
| out_valid | output | 3 | Lane valid bits, lane 0 oldest |
| out_ready | input | 1 | Consumer takes all valid lanes |
| out_bytes | output | 360 | 15 bytes per lane, lane k in bits 120k+119:120k |
| out_len | output | 12 | 4-bit length per lane |
| out_ofs | output | 12 | 4-bit start position in fetch group per lane |
| out_path | output | 6 | 2-bit decode-path code per lane |
| err_drop | output | 1 | One-cycle pulse when an unterminated instruction is dropped |

## Verification
Some properties are checked on every cycle. Valid lanes stay contiguous from lane 0, lane 0 always has a non-zero length and a legal path code, and a stalled lane 0 keeps its length and bytes. Flush holds both handshakes low and leaves the lanes empty on the next cycle, and the buffer never overflows. Other behaviour only the bench's scenarios can show. These are the exact byte contents and offsets of every length at every start position, assembly across group boundaries, and program order. They also include discarding orphan bytes, dropping exactly one unterminated instruction while its successors survive, and the loss of a partially buffered stream on flush.

// File: rtl/ibp_pkg.sv
`timescale 1ns/1ps
package ibp_pkg;
  typedef enum logic [1:0] {
    PATH_SINGLE = 2'b00,
    PATH_DOUBLE = 2'b01,
    PATH_VECTOR = 2'b10
  } path_e;

  function automatic path_e class_to_path(input logic [1:0] cls);
    case (cls)
      2'b00:   return PATH_SINGLE;
      2'b01:   return PATH_DOUBLE;
      default: return PATH_VECTOR;
    endcase
  endfunction
endpackage

// File: rtl/ibp_slot_find.sv
`timescale 1ns/1ps
module ibp_slot_find #(
  parameter int BB = 32,
  parameter int ML = 15,
  localparam int PW = $clog2(BB + 1),
  localparam int IW = $clog2(BB),
  localparam int LW = $clog2(ML + 1)
) (
  input  logic          go,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] occ,
  input  logic [BB-1:0] st,
  input  logic [BB-1:0] en,
  output logic          hit,
  output logic          err,
  output logic [PW-1:0] s_idx,
  output logic [LW-1:0] len,
  output logic [PW-1:0] pos_out
);
  logic          found_s;
  logic          found_e;
  logic [PW:0]   e_w;
  logic [PW-1:0] avail;

  always_comb begin
    found_s = 1'b0;
    s_idx   = occ;
    for (int i = 0; i < BB; i++) begin
      if (!found_s && PW'(i) >= pos && PW'(i) < occ && st[i]) begin
        s_idx   = PW'(i);
        found_s = 1'b1;
      end
    end

    found_e = 1'b0;
    len     = '0;
    e_w     = '0;
    for (int j = 0; j < ML; j++) begin
      e_w = {1'b0, s_idx} + (PW+1)'(j);
      if (!found_e && found_s && e_w < {1'b0, occ} && en[e_w[IW-1:0]]) begin
        found_e = 1'b1;
        len     = LW'(j + 1);
      end
    end

    avail = occ - s_idx;
    hit   = go && found_s && found_e;
    err   = go && found_s && !found_e && (avail >= PW'(ML));

    if (!go)          pos_out = pos;
    else if (!found_s) pos_out = occ;
    else if (found_e) pos_out = s_idx + PW'(len);
    else if (err)     pos_out = s_idx + PW'(ML);
    else              pos_out = s_idx;
  end
endmodule

// File: rtl/ibp_byte_buf.sv
`timescale 1ns/1ps
module ibp_byte_buf #(
  parameter int GB = 16,
  parameter int BB = 32,
  localparam int PW = $clog2(BB + 1),
  localparam int IW = $clog2(BB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [PW-1:0] consume,
  input  logic          push,
  input  logic [7:0]    push_byte [GB],
  input  logic [GB-1:0] push_st,
  input  logic [GB-1:0] push_en,
  input  logic [1:0]    push_cls [GB],
  output logic [PW-1:0] occ,
  output logic [7:0]    q_byte [BB],
  output logic [BB-1:0] q_st,
  output logic [BB-1:0] q_en,
  output logic [1:0]    q_cls [BB]
);
  logic [PW-1:0] n_occ;
  logic [PW-1:0] base;
  logic [7:0]    n_byte [BB];
  logic [BB-1:0] n_st;
  logic [BB-1:0] n_en;
  logic [1:0]    n_cls [BB];
  logic [PW:0]   src;
  logic [PW:0]   dst;

  always_comb begin
    base = occ - consume;
    src  = '0;
    dst  = '0;
    for (int i = 0; i < BB; i++) begin
      src = (PW+1)'(i) + {1'b0, consume};
      if (src < {1'b0, occ}) begin
        n_byte[i] = q_byte[src[IW-1:0]];
        n_st[i]   = q_st[src[IW-1:0]];
        n_en[i]   = q_en[src[IW-1:0]];
        n_cls[i]  = q_cls[src[IW-1:0]];
      end else begin
        n_byte[i] = 8'h00;
        n_st[i]   = 1'b0;
        n_en[i]   = 1'b0;
        n_cls[i]  = 2'b00;
      end
    end
    n_occ = base;
    if (push) begin
      for (int g = 0; g < GB; g++) begin
        dst = {1'b0, base} + (PW+1)'(g);
        if (dst < (PW+1)'(BB)) begin
          n_byte[dst[IW-1:0]] = push_byte[g];
          n_st[dst[IW-1:0]]   = push_st[g];
          n_en[dst[IW-1:0]]   = push_en[g];
          n_cls[dst[IW-1:0]]  = push_cls[g];
        end
      end
      n_occ = base + PW'(GB);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ  <= '0;
      q_st <= '0;
      q_en <= '0;
      for (int i = 0; i < BB; i++) begin
        q_byte[i] <= 8'h00;
        q_cls[i]  <= 2'b00;
      end
    end else if (flush) begin
      occ  <= '0;
      q_st <= '0;
      q_en <= '0;
    end else begin
      occ  <= n_occ;
      q_st <= n_st;
      q_en <= n_en;
      for (int i = 0; i < BB; i++) begin
        q_byte[i] <= n_byte[i];
        q_cls[i]  <= n_cls[i];
      end
    end
  end
endmodule

// File: rtl/insn_boundary_picker.sv
`timescale 1ns/1ps
module insn_boundary_picker
  import ibp_pkg::*;
#(
  parameter int GB    = 16,
  parameter int BB    = 32,
  parameter int ML    = 15,
  parameter int LANES = 3,
  localparam int PW = $clog2(BB + 1),
  localparam int IW = $clog2(BB),
  localparam int LW = $clog2(ML + 1),
  localparam int OW = $clog2(GB)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [GB*8-1:0]         in_bytes,
  input  logic [GB-1:0]           in_start,
  input  logic [GB-1:0]           in_end,
  input  logic [GB*2-1:0]         in_class,
  output logic [LANES-1:0]        out_valid,
  input  logic                    out_ready,
  output logic [LANES*ML*8-1:0]   out_bytes,
  output logic [LANES*LW-1:0]     out_len,
  output logic [LANES*OW-1:0]     out_ofs,
  output logic [LANES*2-1:0]      out_path,
  output logic                    err_drop
);
  logic [7:0]    push_byte [GB];
  logic [1:0]    push_cls [GB];
  logic          push;
  logic [PW-1:0] occ;
  logic [PW-1:0] consume;
  logic [7:0]    q_byte [BB];
  logic [BB-1:0] q_st;
  logic [BB-1:0] q_en;
  logic [1:0]    q_cls [BB];

  logic [LANES:0]   go_c;
  logic [PW-1:0]    pos_c [LANES+1];
  logic [LANES-1:0] hit_l;
  logic [LANES-1:0] err_l;
  logic [PW-1:0]    s_l [LANES];
  logic [LW-1:0]    len_l [LANES];

  logic          commit;
  logic [OW-1:0] head_ofs;
  logic          err_q;

  for (genvar g = 0; g < GB; g++) begin : g_unpack
    assign push_byte[g] = in_bytes[g*8 +: 8];
    assign push_cls[g]  = in_class[g*2 +: 2];
  end

  assign in_ready = !flush && (occ <= PW'(BB - GB));
  assign push     = in_valid && in_ready;

  ibp_byte_buf #(.GB(GB), .BB(BB)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .consume   (consume),
    .push      (push),
    .push_byte (push_byte),
    .push_st   (in_start),
    .push_en   (in_end),
    .push_cls  (push_cls),
    .occ       (occ),
    .q_byte    (q_byte),
    .q_st      (q_st),
    .q_en      (q_en),
    .q_cls     (q_cls)
  );

  assign go_c[0]  = 1'b1;
  assign pos_c[0] = '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ML*8-1:0] lane_bytes;
    logic [PW:0]     idx;

    ibp_slot_find #(.BB(BB), .ML(ML)) u_find (
      .go      (go_c[k]),
      .pos     (pos_c[k]),
      .occ     (occ),
      .st      (q_st),
      .en      (q_en),
      .hit     (hit_l[k]),
      .err     (err_l[k]),
      .s_idx   (s_l[k]),
      .len     (len_l[k]),
      .pos_out (pos_c[k+1])
    );
    assign go_c[k+1] = hit_l[k];

    always_comb begin
      idx = '0;
      for (int b = 0; b < ML; b++) begin
        idx = {1'b0, s_l[k]} + (PW+1)'(b);
        if (LW'(b) < len_l[k] && idx < (PW+1)'(BB))
          lane_bytes[b*8 +: 8] = q_byte[idx[IW-1:0]];
        else
          lane_bytes[b*8 +: 8] = 8'h00;
      end
    end

    assign out_bytes[k*ML*8 +: ML*8] = lane_bytes;
    assign out_len[k*LW +: LW]       = len_l[k];
    assign out_ofs[k*OW +: OW]       = head_ofs + s_l[k][OW-1:0];
    assign out_path[k*2 +: 2]        = class_to_path(q_cls[s_l[k][IW-1:0]]);
  end

  assign out_valid = hit_l & {LANES{!flush}};
  assign commit    = hit_l[0] ? out_ready : 1'b1;
  assign consume   = (flush || !commit) ? '0 : pos_c[LANES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ofs <= '0;
      err_q    <= 1'b0;
    end else if (flush) begin
      head_ofs <= '0;
      err_q    <= 1'b0;
    end else begin
      head_ofs <= head_ofs + consume[OW-1:0];
      err_q    <= commit && (|err_l);
    end
  end

  assign err_drop = err_q;
endmodule

// File: rtl/ibp_checker.sv
`timescale 1ns/1ps
module ibp_checker #(
  parameter int GB    = 16,
  parameter int BB    = 32,
  parameter int ML    = 15,
  parameter int LANES = 3,
  localparam int PW = $clog2(BB + 1),
  localparam int LW = $clog2(ML + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] out_valid,
  input logic             out_ready,
  input logic [ML*8-1:0]  lane0_bytes,
  input logic [LW-1:0]    lane0_len,
  input logic [1:0]       lane0_path,
  input logic [PW-1:0]    occ
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(BB)); // R1
  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> occ >= PW'(GB)); // R1
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> lane0_len != '0); // R2
  AST_PATH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> lane0_path != 2'b11); // R4
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + LANES'(1)) & out_valid) == '0); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] && !out_ready && !flush |=>
      flush || (out_valid[0] && $stable(lane0_len) && $stable(lane0_bytes))); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready && out_valid == '0); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> out_valid == '0 && occ == '0); // R10
endmodule

bind insn_boundary_picker ibp_checker #(.GB(GB), .BB(BB), .ML(ML), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .lane0_bytes (out_bytes[ML*8-1:0]),
  .lane0_len   (out_len[LW-1:0]),
  .lane0_path  (out_path[1:0]),
  .occ         (occ)
);

// File: tb/insn_boundary_picker_bench.sv
`timescale 1ns/1ps
module insn_boundary_picker_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         flush;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_bytes;
  logic [15:0]  in_start;
  logic [15:0]  in_end;
  logic [31:0]  in_class;
  logic [2:0]   out_valid;
  logic         out_ready;
  logic [359:0] out_bytes;
  logic [11:0]  out_len;
  logic [11:0]  out_ofs;
  logic [5:0]   out_path;
  logic         err_drop;

  insn_boundary_picker u_insn_boundary_picker (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_bytes(in_bytes),
    .in_start(in_start), .in_end(in_end), .in_class(in_class),
    .out_valid(out_valid), .out_ready(out_ready), .out_bytes(out_bytes),
    .out_len(out_len), .out_ofs(out_ofs), .out_path(out_path),
    .err_drop(err_drop)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  int sb   [8192];
  bit sst  [8192];
  bit sen  [8192];
  int scls [8192];
  int s_n;
  int e_pos  [4096];
  int e_len  [4096];
  int e_path [4096];
  int e_n;
  int e_err;
  int ei;
  int errs_seen;
  int three_seen;
  bit [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]);
  endfunction

  task automatic clear_stream();
    s_n = 0; e_n = 0; e_err = 0;
  endtask

  task automatic put_byte(input bit b_st, input bit b_en, input int cls);
    sb[s_n]   = (s_n * 13 + 5) & 255;
    sst[s_n]  = b_st;
    sen[s_n]  = b_en;
    scls[s_n] = cls;
    s_n++;
  endtask

  task automatic add_insn(input int len, input int cls);
    e_pos[e_n]  = s_n;
    e_len[e_n]  = len;
    e_path[e_n] = (cls == 3) ? 2 : cls;
    e_n++;
    for (int b = 0; b < len; b++)
      put_byte(b == 0, b == len - 1, (b == 0) ? cls : 3 - cls);
  endtask

  task automatic add_junk(input int n);
    for (int b = 0; b < n; b++) put_byte(1'b0, 1'b0, 1);
  endtask

  task automatic add_bad();
    put_byte(1'b1, 1'b0, 0);
    add_junk(16);
    e_err++;
  endtask

  task automatic pad_group();
    while (s_n % 16 != 0) add_junk(1);
  endtask

  task automatic check_lane(input int k);
    logic [119:0] expb;
    int p;
    int l;
    if (ei >= e_n) begin
      chk(1'b0, "R2", "unexpected extra instruction", 128'(k), 128'(e_n));
      return;
    end
    p = e_pos[ei];
    l = e_len[ei];
    expb = '0;
    for (int b = 0; b < l; b++) expb[b*8 +: 8] = 8'(sb[p + b]);
    chk(out_len[k*4 +: 4] == 4'(l), "R2", "length", 128'(out_len[k*4 +: 4]), 128'(l));
    chk(out_path[k*2 +: 2] == 2'(e_path[ei]), "R4", "path code",
        128'(out_path[k*2 +: 2]), 128'(e_path[ei]));
    chk(out_ofs[k*4 +: 4] == 4'(p % 16), "R7", "group offset",
        128'(out_ofs[k*4 +: 4]), 128'(p % 16));
    if ((p / 16) != ((p + l - 1) / 16))
      chk(out_bytes[k*120 +: 120] == expb, "R3", "spanning bytes",
          128'(out_bytes[k*120 +: 120]), 128'(expb));
    else
      chk(out_bytes[k*120 +: 120] == expb, "R2", "bytes",
          128'(out_bytes[k*120 +: 120]), 128'(expb));
    ei++;
  endtask

  task automatic drive_group(input int gi);
    for (int g = 0; g < 16; g++) begin
      int p;
      p = gi * 16 + g;
      in_bytes[g*8 +: 8]  = 8'(sb[p]);
      in_start[g]         = sst[p];
      in_end[g]           = sen[p];
      in_class[g*2 +: 2]  = 2'(scls[p]);
    end
  endtask

  // rmode 0: always ready; 1: ready two cycles of three; 2: stalled for ten cycles first
  task automatic run_stream(input int rmode, input int limit);
    int gi;
    int cyc;
    int quiet;
    bit acc;
    logic [3:0]   held_len;
    logic [119:0] held_bytes;
    gi = 0; cyc = 0; quiet = 0; acc = 1'b0;
    ei = 0; errs_seen = 0; three_seen = 0;
    held_len = '0; held_bytes = '0;
    while (quiet < 4 && cyc < limit) begin
      @(negedge clk);
      if (acc) gi++;
      in_valid = (gi * 16 < s_n);
      if (in_valid) drive_group(gi);
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc >= 10);
      endcase
      #1;
      if (out_valid == 3'b111) three_seen++;
      if (err_drop) errs_seen++;
      if (rmode == 2 && cyc == 3) begin
        held_len   = out_len[3:0];
        held_bytes = out_bytes[119:0];
      end
      if (rmode == 2 && cyc == 9) begin
        chk(in_ready == 1'b0, "R1", "ready low with 32 bytes held", 128'(in_ready), 128'(0));
        chk(out_valid == 3'b111, "R5", "three lanes while stalled", 128'(out_valid), 128'(7));
        chk(out_len[3:0] == held_len && out_bytes[119:0] == held_bytes, "R6",
            "lane 0 held during stall", 128'(out_len[3:0]), 128'(held_len));
      end
      if (out_ready)
        for (int k = 0; k < 3; k++)
          if (out_valid[k]) check_lane(k);
      acc = in_valid && in_ready;
      if (gi * 16 >= s_n && !acc && ei >= e_n) quiet++;
      else quiet = 0;
      cyc++;
    end
    in_valid = 1'b0;
    chk(cyc < limit, "R2", "stream completes", 128'(cyc), 128'(limit));
    chk(ei == e_n, "R5", "all instructions in order", 128'(ei), 128'(e_n));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    in_valid = 1'b0;
    #1;
    chk(in_ready == 1'b0, "R10", "ready low during flush", 128'(in_ready), 128'(0));
    chk(out_valid == 3'b000, "R10", "lanes low during flush", 128'(out_valid), 128'(0));
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk(out_valid == 3'b000, "R10", "buffer empty after flush", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R1", "ready after flush", 128'(in_ready), 128'(1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_bytes = '0; in_start = '0; in_end = '0; in_class = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(out_valid == 3'b000, "R11", "lanes after reset", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R11", "ready after reset", 128'(in_ready), 128'(1));
    chk(err_drop == 1'b0, "R11", "error after reset", 128'(err_drop), 128'(0));

    // Sweep: every length 1..15 at every start offset 0..15, classes rotating
    clear_stream();
    begin
      int c;
      c = 0;
      for (int l = 1; l <= 15; l++)
        for (int o = 0; o < 16; o++) begin
          while (s_n % 16 != o) begin add_insn(1, c % 4); c++; end
          add_insn(l, c % 4); c++;
        end
    end
    pad_group();
    run_stream(0, 20000);
    chk(errs_seen == 0, "R9", "no error on well formed sweep", 128'(errs_seen), 128'(0));
    chk(three_seen > 0, "R5", "three lanes in one cycle", 128'(three_seen), 128'(1));

    // Mixed lengths, orphan bytes, one unterminated instruction, throttled consumer
    do_flush();
    clear_stream();
    add_junk(20);
    for (int i = 0; i < 30; i++) add_insn(next_rand() % 15 + 1, next_rand() % 4);
    add_bad();
    add_junk(3);
    for (int i = 0; i < 30; i++) add_insn(next_rand() % 15 + 1, next_rand() % 4);
    pad_group();
    run_stream(1, 20000);
    chk(errs_seen == e_err, "R9", "one drop pulse", 128'(errs_seen), 128'(e_err));
    chk(ei == e_n, "R8", "orphan bytes left no output", 128'(ei), 128'(e_n));

    // Back-pressure: consumer stalled while groups arrive
    do_flush();
    clear_stream();
    for (int i = 0; i < 40; i++) add_insn(i % 3 + 1, i % 3);
    pad_group();
    run_stream(2, 20000);

    // Flush discards buffered instructions
    do_flush();
    clear_stream();
    for (int i = 0; i < 16; i++) add_insn(1, 1);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    drive_group(0);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 3'b111, "R5", "lanes visible before flush", 128'(out_valid), 128'(7));
    do_flush();
    clear_stream();
    add_insn(5, 2);
    add_insn(14, 0);
    add_insn(3, 3);
    pad_group();
    run_stream(0, 2000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule